// File: doc/BRIEF.md
# FPGA Configuration Load Sequencer

This block sits on the host side of a board and configures a slave FPGA through a byte-wide parallel load port. It also owns that FPGA's three control lines: an active-low PROGRAM output, an open-drain INIT line and a DONE input. A start pulse with a byte count begins a load. The sequencer first checks that a configuration port is fitted. It then raises an optional power or enable output and releases its low driver on INIT. Next it holds PROGRAM low for a fixed number of cycles and waits for the slave to raise INIT. It streams the configuration bytes from a valid/ready source into the load port and waits for DONE. At the end it reports one of four result codes.

The byte source follows valid/ready rules. A byte moves on a rising edge where `s_valid_i` and `s_ready_o` are both high. `s_ready_o` is high only during the streaming phase. The source may hold `s_valid_i` low for any number of cycles, and the sequencer waits without a time limit during that phase. The source must keep its data steady while `s_valid_i` is high and no transfer has taken place. INIT and DONE each pass through a two-flop synchronizer before the state machine reads them. The PROGRAM pulse width and both timeout limits are parameters counted in clock cycles.

Top module: `cfg_load_seq`

## Requirements
- R1: If `port_present_i` is low when a start is accepted, `fin_o` pulses on the next clock with `result_o` = 1 (no port). `busy_o` stays low, and `prog_n_o`, `en_o` and `init_hold_o` do not change.
- R2: When `USE_ENABLE` is set, `en_o` rises in the same cycle that `busy_o` rises and falls in the cycle the load ends, whatever the result. `en_o` is never high while the block is idle.
- R3: `init_hold_o` (1 = INIT pulled low) is high out of reset. The start of a load clears it at least one cycle before `prog_n_o` falls, and it stays low afterwards.
- R4: `prog_n_o` is low for exactly `PROG_LOW_CYC` clock cycles per load and is high at all other times.
- R5: If synchronized INIT is not high within `INIT_TMO` cycles after `prog_n_o` rises, the load ends with `result_o` = 2. `fin_o` pulses `INIT_TMO` cycles after the rise, and no byte is written.
- R6: Each accepted source byte produces exactly one single-cycle `wr_stb_o` on the next cycle, with that byte on `wr_data_o`. Bytes go out in arrival order, and `s_ready_o` is high only during streaming.
- R7: If synchronized DONE does not go high within `DONE_TMO` cycles after the last byte, the load ends with `result_o` = 3.
- R8: A load that sees INIT and then DONE ends with `result_o` = 0, after exactly `byte_count_i` strobes.
- R9: With a byte count of zero, no byte is requested or written, and the sequencer goes straight from the INIT wait to the DONE wait.
- R10: A start pulse that arrives while `busy_o` is high is ignored. The running load gives exactly one `fin_o` and its own result.
- R11: `fin_o` is a one-cycle pulse in a cycle where `busy_o` is low. `result_o` changes only together with `fin_o` and holds its value until the next load ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; ignored while busy |
| byte_count_i | input | CNT_W | Number of configuration bytes, sampled at start |
| port_present_i | input | 1 | A configuration port is fitted |
| s_valid_i | input | 1 | Byte source has a byte |
| s_data_i | input | DW | Byte from the source |
| s_ready_o | output | 1 | Sequencer takes a byte this cycle |
| init_hold_o | output | 1 | 1 = drive the open-drain INIT line low |
| prog_n_o | output | 1 | PROGRAM, active low |
| init_i | input | 1 | INIT line level from the slave (asynchronous) |
| done_i | input | 1 | DONE line level from the slave (asynchronous) |
| en_o | output | 1 | Optional slave enable, high during a load |
| wr_stb_o | output | 1 | Load-port write strobe, one per byte |
| wr_data_o | output | DW | Load-port write data |
| busy_o | output | 1 | A load is in progress |
| fin_o | output | 1 | One-cycle end-of-load pulse |
| result_o | output | 2 | 0 ok, 1 no port, 2 INIT timeout, 3 DONE timeout |

## Verification
The bench builds the block with `PROG_LOW_CYC` = 6, `INIT_TMO` = 40, `DONE_TMO` = 60 and a 12-bit count. With these values both timeout paths finish within a few dozen cycles, so an INIT timeout can be measured to the exact cycle. An INIT that arrives late but still inside its window can also be tested against the limit. The short PROGRAM pulse keeps many loads, with and without source stalls, inside the cycle budget. A model of the slave drives INIT and DONE from the PROGRAM edge and the strobe count.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REL,
    ST_PLOW,
    ST_WINIT,
    ST_STREAM,
    ST_WDONE
  } seq_st_e;

  localparam logic [1:0] RES_OK     = 2'd0;
  localparam logic [1:0] RES_NOPORT = 2'd1;
  localparam logic [1:0] RES_NOINIT = 2'd2;
  localparam logic [1:0] RES_NODONE = 2'd3;
endpackage

// File: rtl/cls_sync2.sv
module cls_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cls_cycle_ctr.sv
module cls_cycle_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/cls_byte_pump.sv
module cls_byte_pump #(
  parameter int CNT_W = 32,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  input  logic             active,
  input  logic             s_valid_i,
  input  logic [DW-1:0]    s_data_i,
  output logic             s_ready_o,
  output logic             wr_stb_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             last_o,
  output logic             none_o
);
  logic [CNT_W-1:0] left;
  logic             take;

  assign s_ready_o = active;
  assign take      = active && s_valid_i;
  assign last_o    = take && (left == CNT_W'(1));
  assign none_o    = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left      <= '0;
      wr_stb_o  <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= take;
      if (take) wr_data_o <= s_data_i;
      if (load)      left <= count;
      else if (take) left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfg_load_pkg::*;
#(
  parameter int PROG_LOW_CYC = 20,
  parameter int INIT_TMO     = 10_000_000,
  parameter int DONE_TMO     = 100_000_000,
  parameter int CNT_W        = 32,
  parameter int DW           = 8,
  parameter bit USE_ENABLE   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic             port_present_i,
  input  logic             s_valid_i,
  input  logic [DW-1:0]    s_data_i,
  output logic             s_ready_o,
  output logic             init_hold_o,
  output logic             prog_n_o,
  input  logic             init_i,
  input  logic             done_i,
  output logic             en_o,
  output logic             wr_stb_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             busy_o,
  output logic             fin_o,
  output logic [1:0]       result_o
);
  localparam int TMAX_A = (DONE_TMO > INIT_TMO) ? DONE_TMO : INIT_TMO;
  localparam int TMAX   = (TMAX_A > PROG_LOW_CYC) ? TMAX_A : PROG_LOW_CYC;
  localparam int TW     = $clog2(TMAX) + 1;
  localparam logic [TW-1:0] PLOW_LAST = TW'(PROG_LOW_CYC - 1);
  localparam logic [TW-1:0] INIT_LAST = TW'(INIT_TMO - 1);
  localparam logic [TW-1:0] DONE_LAST = TW'(DONE_TMO - 1);

  seq_st_e     st, st_nxt;
  logic [TW-1:0] tcnt;
  logic        tclr, tinc;
  logic        fin_set;
  logic [1:0]  res_set;
  logic [1:0]  pins_s;
  logic        init_s, done_s;
  logic        go, pump_last, pump_none;

  cls_sync2 #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({done_i, init_i}), .q(pins_s)
  );
  assign init_s = pins_s[0];
  assign done_s = pins_s[1];

  cls_cycle_ctr #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tclr), .inc(tinc), .count(tcnt)
  );

  assign go = (st == ST_IDLE) && start_i && port_present_i;

  cls_byte_pump #(.CNT_W(CNT_W), .DW(DW)) u_pump (
    .clk(clk), .rst_n(rst_n), .load(go), .count(byte_count_i),
    .active(st == ST_STREAM), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
    .s_ready_o(s_ready_o), .wr_stb_o(wr_stb_o), .wr_data_o(wr_data_o),
    .last_o(pump_last), .none_o(pump_none)
  );

  always_comb begin
    st_nxt  = st;
    fin_set = 1'b0;
    res_set = RES_OK;
    tinc    = 1'b0;
    case (st)
      ST_IDLE: begin
        if (start_i) begin
          if (!port_present_i) begin
            fin_set = 1'b1;
            res_set = RES_NOPORT;
          end else begin
            st_nxt = ST_REL;
          end
        end
      end
      ST_REL: st_nxt = ST_PLOW;
      ST_PLOW: begin
        if (tcnt == PLOW_LAST) st_nxt = ST_WINIT;
        else                   tinc   = 1'b1;
      end
      ST_WINIT: begin
        if (init_s) begin
          st_nxt = pump_none ? ST_WDONE : ST_STREAM;
        end else if (tcnt == INIT_LAST) begin
          fin_set = 1'b1;
          res_set = RES_NOINIT;
          st_nxt  = ST_IDLE;
        end else begin
          tinc = 1'b1;
        end
      end
      ST_STREAM: begin
        if (pump_last) st_nxt = ST_WDONE;
      end
      ST_WDONE: begin
        if (done_s) begin
          fin_set = 1'b1;
          res_set = RES_OK;
          st_nxt  = ST_IDLE;
        end else if (tcnt == DONE_LAST) begin
          fin_set = 1'b1;
          res_set = RES_NODONE;
          st_nxt  = ST_IDLE;
        end else begin
          tinc = 1'b1;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
    tclr = (st_nxt != st);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      en_o        <= 1'b0;
      init_hold_o <= 1'b1;
      prog_n_o    <= 1'b1;
      fin_o       <= 1'b0;
      result_o    <= RES_OK;
    end else begin
      st    <= st_nxt;
      fin_o <= fin_set;
      if (fin_set) begin
        result_o <= res_set;
        en_o     <= 1'b0;
      end
      if (go) begin
        en_o        <= USE_ENABLE;
        init_hold_o <= 1'b0;
      end
      if (st == ST_REL) prog_n_o <= 1'b0;
      if ((st == ST_PLOW) && (st_nxt == ST_WINIT)) prog_n_o <= 1'b1;
    end
  end

  assign busy_o = (st != ST_IDLE);
endmodule

// File: rtl/cfg_load_chk.sv
module cfg_load_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       s_valid_i,
  input logic       s_ready_o,
  input logic       init_hold_o,
  input logic       prog_n_o,
  input logic       en_o,
  input logic       wr_stb_o,
  input logic       busy_o,
  input logic       fin_o,
  input logic [1:0] result_o
);
  // R1
  noport_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_o && result_o == 2'd1) |-> (prog_n_o && !en_o));
  // R2
  en_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |-> busy_o);
  // R3
  prog_after_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> !init_hold_o);
  // R3
  rel_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_n_o) |-> !$past(init_hold_o));
  // R6
  stb_from_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> $past(s_valid_i && s_ready_o));
  // R6
  ready_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> busy_o);
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || fin_o));
  // R11
  fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o);
  // R11
  fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> !busy_o);
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_o |-> $stable(result_o));
endmodule

bind cfg_load_seq cfg_load_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .s_valid_i(s_valid_i),
  .s_ready_o(s_ready_o), .init_hold_o(init_hold_o), .prog_n_o(prog_n_o),
  .en_o(en_o), .wr_stb_o(wr_stb_o), .busy_o(busy_o), .fin_o(fin_o),
  .result_o(result_o)
);

// File: tb/sim_cfg_load_seq.sv
module sim_cfg_load_seq;
  localparam int PLOW = 6;
  localparam int ITMO = 40;
  localparam int DTMO = 60;
  localparam int CW   = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, port_present_i = 1'b0;
  logic [CW-1:0] byte_count_i = '0;
  logic s_valid_i = 1'b0;
  logic [7:0] s_data_i = '0;
  logic init_i = 1'b0, done_i = 1'b0;
  logic s_ready_o, init_hold_o, prog_n_o, en_o, wr_stb_o, busy_o, fin_o;
  logic [7:0] wr_data_o;
  logic [1:0] result_o;

  cfg_load_seq #(.PROG_LOW_CYC(PLOW), .INIT_TMO(ITMO), .DONE_TMO(DTMO),
                 .CNT_W(CW), .DW(8), .USE_ENABLE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
    .port_present_i(port_present_i), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
    .s_ready_o(s_ready_o), .init_hold_o(init_hold_o), .prog_n_o(prog_n_o),
    .init_i(init_i), .done_i(done_i), .en_o(en_o), .wr_stb_o(wr_stb_o),
    .wr_data_o(wr_data_o), .busy_o(busy_o), .fin_o(fin_o), .result_o(result_o)
  );

  always #5 clk = ~clk;

  int checks = 0, bad = 0;
  logic [7:0] src_q[$];
  logic [7:0] exp_q[$];
  logic [1:0] res_q[$];
  int init_dly = 0, done_dly = 0, target = 0, done_cnt = 0, prog_hi = 0;
  int fin_seen = 0, strobes = 0, prog_falls = 0, plow_cnt = 0, last_width = 0;
  int en_bad = 0, r3_bad = 0, hi_at_fin = 0, cyc = 0;
  bit stall_on = 1'b0, armed = 1'b0;
  logic prev_prog = 1'b1, prev_hold = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave model, byte source and monitors, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!prog_n_o) begin
      init_i = 1'b0; done_i = 1'b0; prog_hi = 0; done_cnt = 0; armed = 1'b1;
    end else if (armed) begin
      prog_hi++;
      if (init_dly >= 0 && prog_hi >= init_dly) init_i = 1'b1;
      if (init_i && strobes == target) begin
        done_cnt++;
        if (done_dly >= 0 && done_cnt >= done_dly) done_i = 1'b1;
      end
    end
    if (busy_o != en_o) en_bad++;
    if (!prog_n_o && prev_prog) begin
      prog_falls++; plow_cnt = 1;
      if (prev_hold) r3_bad++;
    end else if (!prog_n_o) plow_cnt++;
    if (prog_n_o && !prev_prog) last_width = plow_cnt;
    prev_prog = prog_n_o; prev_hold = init_hold_o;
    if (wr_stb_o) begin
      strobes++;
      if (src_q.size() > 0) void'(src_q.pop_front());
      if (exp_q.size() == 0) chk(1'b0, "R6 extra strobe", wr_data_o, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(wr_data_o == e, "R6 byte order", wr_data_o, e);
      end
    end
    if (fin_o) begin
      fin_seen++;
      hi_at_fin = prog_hi;
      if (res_q.size() == 0) chk(1'b0, "R10 extra fin", result_o, -1);
      else begin
        logic [1:0] er;
        er = res_q.pop_front();
        chk(result_o == er, "R5/R7/R8 result code", result_o, er);
      end
    end
    s_valid_i = (src_q.size() > 0) && (!stall_on || cyc[0]);
    if (src_q.size() > 0) s_data_i = src_q[0];
  end

  task automatic run_load(input int n, input bit present, input int idly,
                          input int ddly, input bit stall, input bit dbl,
                          input logic [1:0] exp_res);
    int f0, s0;
    for (int i = 0; i < n; i++) begin
      src_q.push_back(8'(i * 37 + n * 11 + 5));
      exp_q.push_back(8'(i * 37 + n * 11 + 5));
    end
    res_q.push_back(exp_res);
    init_dly = idly; done_dly = ddly; stall_on = stall;
    strobes = 0; target = n; prog_falls = 0; en_bad = 0; r3_bad = 0;
    f0 = fin_seen;
    @(negedge clk);
    start_i = 1'b1; byte_count_i = CW'(n); port_present_i = present;
    @(negedge clk);
    start_i = 1'b0;
    if (!present) chk(fin_o && !busy_o, "R1 immediate fin", fin_o, 1);
    if (dbl) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; port_present_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (fin_seen == f0) @(negedge clk);
    s0 = fin_seen;
    @(negedge clk);
    chk(!fin_o, "R11 fin one cycle", fin_o, 0);
    repeat (4) @(negedge clk);
    chk(fin_seen == s0 && fin_seen == f0 + 1, "R10 one fin per load", fin_seen - f0, 1);
    chk(result_o == exp_res, "R11 result held", result_o, exp_res);
    chk(!en_o && !busy_o && en_bad == 0, "R2 enable tracks load", en_bad, 0);
    src_q.delete(); exp_q.delete(); stall_on = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && prog_n_o && init_hold_o && !en_o && !s_ready_o && !fin_o &&
        result_o == 2'd0, "R3/R11 reset state", busy_o, 0);

    // R1: no port present
    run_load(0, 1'b0, 5, 3, 1'b0, 1'b0, 2'd1);
    chk(prog_falls == 0 && init_hold_o, "R1 pins untouched", prog_falls, 0);

    // R8 and R4: plain load
    run_load(8, 1'b1, 5, 3, 1'b0, 1'b0, 2'd0);
    chk(last_width == PLOW && prog_falls == 1, "R4 PROGRAM width", last_width, PLOW);
    chk(r3_bad == 0 && !init_hold_o, "R3 INIT released first", r3_bad, 0);
    chk(strobes == 8, "R8 strobe count", strobes, 8);

    // R6: source with stalls
    run_load(17, 1'b1, 3, 2, 1'b1, 1'b0, 2'd0);
    chk(strobes == 17, "R6 stalled stream count", strobes, 17);

    // R9: zero bytes
    run_load(0, 1'b1, 4, 2, 1'b0, 1'b0, 2'd0);
    chk(strobes == 0, "R9 no strobes", strobes, 0);

    // R5: INIT never rises
    run_load(5, 1'b1, -1, 2, 1'b0, 1'b0, 2'd2);
    chk(strobes == 0, "R5 no bytes written", strobes, 0);
    chk(hi_at_fin == ITMO + 1, "R5 timeout cycle", hi_at_fin, ITMO + 1);

    // R7: DONE never rises
    run_load(4, 1'b1, 5, -1, 1'b0, 1'b0, 2'd3);
    chk(strobes == 4, "R7 all bytes before wait", strobes, 4);

    // R5 boundary: late INIT still inside window
    run_load(3, 1'b1, ITMO - 10, 2, 1'b0, 1'b0, 2'd0);
    chk(last_width == PLOW, "R4 PROGRAM width again", last_width, PLOW);

    // R10: start while busy
    run_load(6, 1'b1, 6, 4, 1'b0, 1'b1, 2'd0);
    chk(strobes == 6, "R10 load unaffected", strobes, 6);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule